// File: doc/BRIEF.md
# Debug Comparator Event Qualifier

This block sits behind a bank of debug address comparators. Each comparator slot reports a raw hit, produced outside the block once the address and access type agree. The qualifier decides whether that hit becomes an architectural debug event. It applies a global gate, a security-state filter, a privilege filter and an optional link to a context-ID comparator held in another slot.

The control register of every slot enters as separate field vectors. These are the enable (register bit 0), the privilege pair (bits 2:1), the higher-mode bit (bit 13), the security-state code (bits 15:14), the link number (bits 19:16) and the four-bit type nibble (bits 23:20). Bit 0 of the type nibble is the linked flag of the slot itself. When another slot links to this one, the whole nibble is read as that slot's type. The low 32 bits of each slot's value register come in alongside. The number of breakpoints and the number of context-aware comparators arrive minus one, in the identification-register encoding.

The per-slot match vector is combinational. The OR of the vector is registered and gives a one-cycle event.

Top module: `dbg_event_qualifier`

## Requirements
- R1: When bit 15 of `mon_ctrl` is 0, or `dbg_allowed` is 0, every bit of `slot_match` is 0.
- R2: A slot whose `raw_hit` bit is 0 never matches.
- R3: The security code selects the states in which a slot matches. Code 0 matches in either state. Codes 1 and 3 match only when `secure` is 0. Code 2 matches only when `secure` is 1.
- R4: The access level selects the field a slot needs. At levels 2 and 3 the higher-mode bit must be 1. At level 1, privilege bit 0 must be 1. At level 0, privilege bit 1 must be 1.
- R5: With `unpriv` at 1, the privilege filter of R4 uses level 0 whatever `cur_el` is.
- R6: A slot whose linked flag (type bit 0) is 1 matches only if its link target passes. The target must have its enable at 1 and a type nibble equal to 3, and its 32-bit value must equal `ctx_id`. Any other target type, reserved types included, fails.
- R7: A link number above `bp_count_m1`, or below `bp_count_m1 - ctx_count_m1`, or not below the slot count, fails the link.
- R8: A context-ID link fails whenever `cur_el` is above 1. This holds even when `unpriv` is 1.
- R9: `event_q` is 0 after reset. On each clock edge it takes the OR of `slot_match`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| raw_hit | input | NSLOT | Address/type hit per slot from the comparators |
| f_en | input | NSLOT | Enable field per slot |
| f_priv | input | 2*NSLOT | Privilege pair per slot |
| f_hmode | input | NSLOT | Higher-mode bit per slot |
| f_sec | input | 2*NSLOT | Security code per slot |
| f_link | input | 4*NSLOT | Link number per slot |
| f_type | input | 4*NSLOT | Type nibble per slot (bit 0 is the linked flag) |
| cmp_value | input | 32*NSLOT | Low 32 bits of each value register |
| cur_el | input | 2 | Current exception level |
| secure | input | 1 | Current security state is secure |
| unpriv | input | 1 | Access is an unprivileged load or store |
| ctx_id | input | 32 | Current context ID |
| mon_ctrl | input | 32 | Debug monitor control word, bit 15 is the global enable |
| dbg_allowed | input | 1 | Debug exceptions may be taken now |
| bp_count_m1 | input | 4 | Number of breakpoints minus one |
| ctx_count_m1 | input | 4 | Number of context-aware breakpoints minus one |
| slot_match | output | NSLOT | Combinational qualified match per slot |
| event_q | output | 1 | Registered OR of all matches |

## Verification
`slot_match` is due in the same cycle as its inputs, with no register on the way. The bench drives every input on the falling edge and reads the match vector one nanosecond later. `event_q` passes through one register. The bench therefore reads it on the following falling edge, after the rising edge that captured the vector. Each directed task sets the slot fields for one filter and holds all other fields at passing values, so a wrong bit points to a single rule.

// File: rtl/dbg_event_qualifier.sv
module dbg_event_qualifier #(
  parameter int NSLOT = 16,
  parameter int LW    = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NSLOT-1:0]   raw_hit,
  input  logic [NSLOT-1:0]   f_en,
  input  logic [2*NSLOT-1:0] f_priv,
  input  logic [NSLOT-1:0]   f_hmode,
  input  logic [2*NSLOT-1:0] f_sec,
  input  logic [LW*NSLOT-1:0] f_link,
  input  logic [4*NSLOT-1:0] f_type,
  input  logic [32*NSLOT-1:0] cmp_value,
  input  logic [1:0]         cur_el,
  input  logic               secure,
  input  logic               unpriv,
  input  logic [31:0]        ctx_id,
  input  logic [31:0]        mon_ctrl,
  input  logic               dbg_allowed,
  input  logic [LW-1:0]      bp_count_m1,
  input  logic [LW-1:0]      ctx_count_m1,
  output logic [NSLOT-1:0]   slot_match,
  output logic               event_q
);

  localparam logic [3:0] CTX_TYPE = 4'd3;

  logic [1:0] acc_el;
  logic       gate;
  logic       ctx_level_ok;
  logic [NSLOT-1:0] ctx_pass;

  assign gate         = mon_ctrl[15] & dbg_allowed;
  assign acc_el       = unpriv ? 2'd0 : cur_el;
  assign ctx_level_ok = (cur_el <= 2'd1);

  for (genvar t = 0; t < NSLOT; t++) begin : g_tgt
    assign ctx_pass[t] = f_en[t] && (f_type[4*t +: 4] == CTX_TYPE) &&
                         ctx_level_ok && (cmp_value[32*t +: 32] == ctx_id);
  end

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    logic [1:0]    pac;
    logic [1:0]    ssc;
    logic [LW-1:0] lbn;
    logic          linked;
    logic          sec_ok;
    logic          lvl_ok;
    logic          in_range;
    logic          link_ok;

    assign pac    = f_priv[2*i +: 2];
    assign ssc    = f_sec[2*i +: 2];
    assign lbn    = f_link[LW*i +: LW];
    assign linked = f_type[4*i];

    always_comb begin
      case (ssc)
        2'd0:    sec_ok = 1'b1;
        2'd2:    sec_ok = secure;
        default: sec_ok = !secure;
      endcase
      case (acc_el)
        2'd0:    lvl_ok = pac[1];
        2'd1:    lvl_ok = pac[0];
        default: lvl_ok = f_hmode[i];
      endcase
    end

    assign in_range = (lbn <= bp_count_m1) &&
                      ({1'b0, lbn} + {1'b0, ctx_count_m1} >= {1'b0, bp_count_m1});

    always_comb begin
      link_ok = 1'b0;
      for (int j = 0; j < NSLOT; j++)
        if (lbn == LW'(j)) link_ok = ctx_pass[j];
      link_ok = link_ok && in_range;
    end

    assign slot_match[i] = gate && raw_hit[i] && sec_ok && lvl_ok && (!linked || link_ok);

    assert_needs_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !raw_hit[i] |-> !slot_match[i]);
    assert_sec_secure_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ssc == 2'd2 && !secure) |-> !slot_match[i]);
    assert_sec_nonsecure_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ssc[0] && secure) |-> !slot_match[i]);
    assert_el1_priv_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!unpriv && cur_el == 2'd1 && !pac[0]) |-> !slot_match[i]);
    assert_unpriv_el0_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (unpriv && !pac[1]) |-> !slot_match[i]);
    assert_ctx_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (linked && cur_el > 2'd1) |-> !slot_match[i]);
    assert_link_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (linked && lbn > bp_count_m1) |-> !slot_match[i]);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) event_q <= 1'b0;
    else        event_q <= |slot_match;

  assert_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!mon_ctrl[15] || !dbg_allowed) |-> (slot_match == '0));
  assert_event_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_match != '0) |=> event_q);
  assert_event_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_match == '0) |=> !event_q);

endmodule

// File: tb/dbg_event_qualifier_bench.sv
module dbg_event_qualifier_bench;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] raw_hit, f_en, f_hmode, slot_match;
  logic [2*N-1:0] f_priv, f_sec;
  logic [4*N-1:0] f_link, f_type;
  logic [32*N-1:0] cmp_value;
  logic [1:0] cur_el;
  logic secure, unpriv, dbg_allowed, event_q;
  logic [31:0] ctx_id, mon_ctrl;
  logic [3:0] bp_count_m1, ctx_count_m1;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  dbg_event_qualifier u_dbg_event_qualifier (.*);

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic defaults();
    raw_hit = '0; f_en = '0; f_hmode = '0; f_priv = '0; f_sec = '0;
    f_link = '0; f_type = '0; cmp_value = '0;
    cur_el = 2'd1; secure = 1'b0; unpriv = 1'b0; dbg_allowed = 1'b1;
    ctx_id = 32'h0; mon_ctrl = 32'h0000_8000;
    bp_count_m1 = 4'd5; ctx_count_m1 = 4'd1;
  endtask

  task automatic slot(input int i, input logic [1:0] pac, input logic hmc,
                      input logic [1:0] ssc, input logic [3:0] lbn, input logic [3:0] typ);
    f_priv[2*i +: 2] = pac; f_hmode[i] = hmc; f_sec[2*i +: 2] = ssc;
    f_link[4*i +: 4] = lbn; f_type[4*i +: 4] = typ; f_en[i] = 1'b1;
  endtask

  task automatic apply(input string req, input logic [N-1:0] exp);
    #1 chk(req, slot_match, exp);
    @(negedge clk);
    chk({req, " event"}, {{(N-1){1'b0}}, event_q}, {{(N-1){1'b0}}, |exp});
  endtask

  task automatic t_global();
    defaults(); slot(0, 2'b11, 1'b1, 2'd0, 4'd0, 4'd0); raw_hit[0] = 1'b1;
    apply("R1 enabled", 16'h0001);
    mon_ctrl = 32'hFFFF_7FFF; apply("R1 global off", 16'h0000);
    mon_ctrl = 32'h0000_8000; dbg_allowed = 1'b0; apply("R1 not allowed", 16'h0000);
  endtask

  task automatic t_rawhit();
    defaults();
    for (int i = 0; i < 3; i++) slot(i, 2'b11, 1'b1, 2'd0, 4'd0, 4'd0);
    raw_hit = 16'h0004; apply("R2 only hit slot", 16'h0004);
    raw_hit = 16'h0000; apply("R2 no hit", 16'h0000);
  endtask

  task automatic t_secure();
    defaults(); raw_hit[0] = 1'b1;
    slot(0, 2'b11, 1'b1, 2'd2, 4'd0, 4'd0); apply("R3 code2 nonsecure", 16'h0000);
    secure = 1'b1; apply("R3 code2 secure", 16'h0001);
    slot(0, 2'b11, 1'b1, 2'd1, 4'd0, 4'd0); apply("R3 code1 secure", 16'h0000);
    slot(0, 2'b11, 1'b1, 2'd3, 4'd0, 4'd0); secure = 1'b0; apply("R3 code3 nonsecure", 16'h0001);
    slot(0, 2'b11, 1'b1, 2'd0, 4'd0, 4'd0); secure = 1'b1; apply("R3 code0 secure", 16'h0001);
  endtask

  task automatic t_level();
    defaults(); raw_hit[0] = 1'b1;
    cur_el = 2'd2; slot(0, 2'b11, 1'b0, 2'd0, 4'd0, 4'd0); apply("R4 el2 no hmc", 16'h0000);
    slot(0, 2'b00, 1'b1, 2'd0, 4'd0, 4'd0); apply("R4 el2 hmc", 16'h0001);
    cur_el = 2'd3; apply("R4 el3 hmc", 16'h0001);
    cur_el = 2'd1; slot(0, 2'b10, 1'b1, 2'd0, 4'd0, 4'd0); apply("R4 el1 pac10", 16'h0000);
    cur_el = 2'd0; apply("R4 el0 pac10", 16'h0001);
    slot(0, 2'b01, 1'b1, 2'd0, 4'd0, 4'd0); apply("R4 el0 pac01", 16'h0000);
  endtask

  task automatic t_unpriv();
    defaults(); raw_hit[0] = 1'b1; unpriv = 1'b1;
    slot(0, 2'b10, 1'b0, 2'd0, 4'd0, 4'd0); apply("R5 unpriv el1 pac10", 16'h0001);
    slot(0, 2'b01, 1'b1, 2'd0, 4'd0, 4'd0); apply("R5 unpriv el1 pac01", 16'h0000);
    cur_el = 2'd3; apply("R5 unpriv el3 hmc", 16'h0000);
  endtask

  task automatic link_setup(input logic [3:0] lbn, input int tgt);
    defaults(); raw_hit[0] = 1'b1;
    slot(0, 2'b11, 1'b1, 2'd0, lbn, 4'd1);
    slot(tgt, 2'b00, 1'b0, 2'd0, 4'd0, 4'd3);
    cmp_value[32*tgt +: 32] = 32'hCAFE_1234; ctx_id = 32'hCAFE_1234;
  endtask

  task automatic t_link();
    link_setup(4'd4, 4); apply("R6 ctx equal", 16'h0001);
    ctx_id = 32'hCAFE_1235; apply("R6 ctx differ", 16'h0000);
    ctx_id = 32'hCAFE_1234; f_en[4] = 1'b0; apply("R6 target disabled", 16'h0000);
    f_en[4] = 1'b1; f_type[16 +: 4] = 4'd5; apply("R6 target type5", 16'h0000);
    f_type[16 +: 4] = 4'd11; apply("R6 target type11", 16'h0000);
  endtask

  task automatic t_range();
    link_setup(4'd3, 3); apply("R7 below window", 16'h0000);
    link_setup(4'd6, 6); apply("R7 above count", 16'h0000);
    link_setup(4'd5, 5); apply("R7 upper edge", 16'h0001);
  endtask

  task automatic t_ctxlvl();
    link_setup(4'd4, 4); cur_el = 2'd2; apply("R8 el2 link", 16'h0000);
    unpriv = 1'b1; apply("R8 el2 unpriv link", 16'h0000);
    cur_el = 2'd0; unpriv = 1'b0; apply("R8 el0 link", 16'h0001);
  endtask

  task automatic t_event();
    defaults();
    slot(1, 2'b11, 1'b1, 2'd0, 4'd0, 4'd0); slot(9, 2'b11, 1'b1, 2'd0, 4'd0, 4'd0);
    raw_hit = 16'h0202; apply("R9 two slots", 16'h0202);
    raw_hit = 16'h0000; apply("R9 drop", 16'h0000);
  endtask

  initial begin
    fork
      begin
        defaults();
        repeat (2) @(negedge clk);
        #1 chk("R9 reset event", {{(N-1){1'b0}}, event_q}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        t_global(); t_rawhit(); t_secure(); t_level(); t_unpriv();
        t_link(); t_range(); t_ctxlvl(); t_event();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule